// File: doc/BRIEF.md
# Signed Integer Encoding Converter

This block re-encodes a signed integer from one storage convention into another. The supported conventions are sign-magnitude, one's complement and two's complement. A value can be held in a narrow (8-bit) word or a wide (16-bit) word. Each request carries four things:

- the input word;
- a code for its encoding and a width select for its source;
- a code for the wanted encoding;
- a width select for the destination.

One clock later the block presents the re-encoded word. With it come a valid strobe, an overflow flag and a flag marking a negative-zero input. The overflow flag is raised when the value has no representation in the destination. The block is used where data crosses between parts of a system that keep integers in different forms.

Internally the source word is reduced to a sign and an unsigned magnitude. The magnitude is compared with the limits of the destination encoding and width. If it fits, it is rebuilt in the destination encoding; if not, the output is forced to zero.

The input side is a single valid strobe with no ready. The block accepts one request on every cycle and applies no back-pressure. A request is never stalled or dropped. The output has no ready either, so a consumer must take each result in the cycle that out_valid is high.

Top module: `sfc_top`

## Requirements
- R1: Encoding codes are 2'b00 sign-magnitude, 2'b01 one's complement and 2'b10 two's complement. Code 2'b11 behaves exactly as two's complement. In every encoding the most significant bit of the word is the sign, with 1 meaning negative.
- R2: A width select of 0 means 8 bits and 1 means 16 bits. For an 8-bit source only in_data[7:0] is used, and bits [15:8] have no effect on any output.
- R3: out_valid is high exactly one cycle after a cycle with in_valid high, and low otherwise. Reset (rst_n low, synchronous) clears out_valid, out_data, out_ovf and out_negz.
- R4: A value inside the destination range is re-encoded with the same numeric value. For example, 8-bit sign-magnitude 0xBB (-59) becomes 8-bit two's complement 0xC5.
- R5: The negative-zero inputs are sign-magnitude 0x80 / 0x8000 and one's complement 0xFF / 0xFFFF. Each sets out_negz and converts to the all-zero word in every encoding. out_negz is 0 for every other input.
- R6: A value outside the destination range sets out_ovf and forces out_data to zero. The ranges are: sign-magnitude and one's complement -127..127 (8 bits) and -32767..32767 (16 bits); two's complement -128..127 (8 bits) and -32768..32767 (16 bits).
- R7: Two's complement -128 (8-bit) or -32768 (16-bit) sent to sign-magnitude or one's complement at the same width sets out_ovf with out_data zero. Sent to two's complement, it converts without overflow.
- R8: Converting from an 8-bit source to a 16-bit destination never sets out_ovf. Every 8-bit destination result has out_data[15:8] equal to zero.
- R9: While in_valid is low, out_data, out_ovf and out_negz keep the values of the last accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_data | input | 16 | Source word (low byte only for 8-bit source) |
| src_fmt | input | 2 | Source encoding code |
| src_wide | input | 1 | Source width select, 1 = 16 bits |
| dst_fmt | input | 2 | Destination encoding code |
| dst_wide | input | 1 | Destination width select, 1 = 16 bits |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Re-encoded word, zero on overflow |
| out_ovf | output | 1 | Value does not fit the destination |
| out_negz | output | 1 | Source word was a negative zero |

## Verification
The assertions check the cycle-level properties on every cycle:

- the one-cycle latency of the valid strobe;
- a zero word with every overflow;
- a clear upper byte for narrow destinations;
- no overflow on widening;
- no overflow together with the negative-zero flag;
- the decoder never handing a signed zero to the range check.

Only the bench scenarios can show that the numeric values are right. That covers values at the edges of each range, the most negative two's complement value, the negative-zero words, upper input bits being ignored and outputs holding while idle. The bench compares each of these against an arithmetic model of the three encodings.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [1:0] {
    FMT_SMAG = 2'b00,
    FMT_ONES = 2'b01,
    FMT_TWOS = 2'b10,
    FMT_TWOS_ALT = 2'b11
  } fmt_e;

  function automatic logic is_twos(input fmt_e f);
    return (f == FMT_TWOS) || (f == FMT_TWOS_ALT);
  endfunction
endpackage

// File: rtl/sfc_decode.sv
module sfc_decode
  import sfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] word,
  input  fmt_e         fmt,
  output logic         neg,
  output logic [W-1:0] mag,
  output logic         negz
);
  logic sgn;
  logic [W-2:0] body;

  assign sgn  = word[W-1];
  assign body = word[W-2:0];

  always_comb begin
    negz = 1'b0;
    mag  = '0;
    case (fmt)
      FMT_SMAG: begin
        mag  = {1'b0, body};
        negz = sgn && (body == '0);
      end
      FMT_ONES: begin
        mag  = sgn ? {1'b0, ~body} : {1'b0, body};
        negz = &word;
      end
      default: begin
        mag = sgn ? (~word + W'(1)) : word;
      end
    endcase
    // a negative zero carries no sign forward
    neg = sgn && !negz;
  end
endmodule

// File: rtl/sfc_range.sv
module sfc_range
  import sfc_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              neg,
  input  logic [WIDE_W-1:0] mag,
  input  logic              dst_wide,
  input  fmt_e              dst_fmt,
  output logic              ovf
);
  localparam logic [WIDE_W:0] WIDE_LIM   = (WIDE_W+1)'((1 << (WIDE_W-1)) - 1);
  localparam logic [WIDE_W:0] NARROW_LIM = (WIDE_W+1)'((1 << (NARROW_W-1)) - 1);

  logic [WIDE_W:0] lim;

  always_comb begin
    lim = dst_wide ? WIDE_LIM : NARROW_LIM;
    // two's complement reaches one step further on the negative side
    if (neg && is_twos(dst_fmt)) lim = lim + (WIDE_W+1)'(1);
    ovf = {1'b0, mag} > lim;
  end
endmodule

// File: rtl/sfc_encode.sv
module sfc_encode
  import sfc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         neg,
  input  logic [W-1:0] mag,
  input  fmt_e         fmt,
  output logic [W-1:0] word
);
  logic [W-1:0] pos;

  assign pos = {1'b0, mag[W-2:0]};

  always_comb begin
    case (fmt)
      FMT_SMAG: word = {neg, mag[W-2:0]};
      FMT_ONES: word = neg ? ~pos : pos;
      default:  word = neg ? (~mag + W'(1)) : mag;
    endcase
  end
endmodule

// File: rtl/sfc_top.sv
module sfc_top
  import sfc_pkg::*;
#(
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WIDE_W-1:0] in_data,
  input  logic [1:0]        src_fmt,
  input  logic              src_wide,
  input  logic [1:0]        dst_fmt,
  input  logic              dst_wide,
  output logic              out_valid,
  output logic [WIDE_W-1:0] out_data,
  output logic              out_ovf,
  output logic              out_negz
);
  localparam int PAD_W = WIDE_W - NARROW_W;

  fmt_e sfmt, dfmt;
  assign sfmt = fmt_e'(src_fmt);
  assign dfmt = fmt_e'(dst_fmt);

  // decode at both widths, then pick by source width
  logic                n_neg, w_neg, n_nz, w_nz;
  logic [NARROW_W-1:0] n_mag;
  logic [WIDE_W-1:0]   w_mag;

  sfc_decode #(.W(NARROW_W)) u_dec_n (
    .word(in_data[NARROW_W-1:0]), .fmt(sfmt),
    .neg(n_neg), .mag(n_mag), .negz(n_nz)
  );
  sfc_decode #(.W(WIDE_W)) u_dec_w (
    .word(in_data), .fmt(sfmt),
    .neg(w_neg), .mag(w_mag), .negz(w_nz)
  );

  logic              s_neg, s_nz, s_ovf;
  logic [WIDE_W-1:0] s_mag;

  assign s_neg = src_wide ? w_neg : n_neg;
  assign s_nz  = src_wide ? w_nz  : n_nz;
  assign s_mag = src_wide ? w_mag : {{PAD_W{1'b0}}, n_mag};

  sfc_range #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_rng (
    .neg(s_neg), .mag(s_mag), .dst_wide(dst_wide), .dst_fmt(dfmt), .ovf(s_ovf)
  );

  // encode at both widths, then pick by destination width
  logic [NARROW_W-1:0] e_n;
  logic [WIDE_W-1:0]   e_w, result;

  sfc_encode #(.W(NARROW_W)) u_enc_n (
    .neg(s_neg), .mag(s_mag[NARROW_W-1:0]), .fmt(dfmt), .word(e_n)
  );
  sfc_encode #(.W(WIDE_W)) u_enc_w (
    .neg(s_neg), .mag(s_mag), .fmt(dfmt), .word(e_w)
  );

  always_comb begin
    if (s_ovf)         result = '0;
    else if (dst_wide) result = e_w;
    else               result = {{PAD_W{1'b0}}, e_n};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_ovf   <= 1'b0;
      out_negz  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= result;
        out_ovf  <= s_ovf;
        out_negz <= s_nz;
      end
    end
  end

  // ---- assertions ----
  assert_valid_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_ovf_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ovf) |-> (out_data == '0));
  assert_narrow_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !dst_wide) |=> (out_data[WIDE_W-1:NARROW_W] == '0));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !src_wide && dst_wide) |=> !out_ovf);
  assert_negz_no_ovf_R5: assert property (@(posedge clk) disable iff (!rst_n)
    out_negz |-> !out_ovf);
  assert_no_signed_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    s_neg |-> (s_mag != '0));
endmodule

// File: tb/sim_sfc_top.sv
module sim_sfc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  src_fmt = '0, dst_fmt = '0;
  logic        src_wide = 1'b0, dst_wide = 1'b0;
  logic        out_valid, out_ovf, out_negz;
  logic [15:0] out_data;

  always #4 clk = ~clk;

  sfc_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .src_fmt(src_fmt), .src_wide(src_wide), .dst_fmt(dst_fmt), .dst_wide(dst_wide),
    .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf), .out_negz(out_negz)
  );

  typedef struct {
    logic [15:0] data;
    logic        ovf;
    logic        nz;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int fails = 0;
  logic [15:0] last_data = '0;
  logic        last_ovf = 1'b0, last_nz = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // arithmetic model of the three encodings
  function automatic exp_t model(input logic [15:0] d, input logic [1:0] sf, input logic sw,
                                 input logic [1:0] df, input logic dw, input string tag);
    exp_t e;
    int n, m, x, v, hi, lo, r;
    n = sw ? 16 : 8;
    m = dw ? 16 : 8;
    x = sw ? int'(d) : int'(d[7:0]);
    if (sf == 2'b00)      v = (x >= (1 << (n-1))) ? -(x - (1 << (n-1))) : x;
    else if (sf == 2'b01) v = (x >= (1 << (n-1))) ? -(((1 << n) - 1) - x) : x;
    else                  v = (x >= (1 << (n-1))) ? x - (1 << n) : x;
    e.nz = (sf == 2'b00 && x == (1 << (n-1))) || (sf == 2'b01 && x == (1 << n) - 1);
    hi = (1 << (m-1)) - 1;
    lo = (df[1]) ? -(1 << (m-1)) : -hi;
    e.ovf = (v < lo) || (v > hi);
    if (e.ovf)            r = 0;
    else if (v >= 0)      r = v;
    else if (df == 2'b00) r = (1 << (m-1)) - v;
    else if (df == 2'b01) r = ((1 << m) - 1) + v;
    else                  r = (1 << m) + v;
    e.data = 16'(r);
    e.tag = tag;
    return e;
  endfunction

  task automatic send(input logic [15:0] d, input logic [1:0] sf, input logic sw,
                      input logic [1:0] df, input logic dw, input string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; src_fmt = sf; src_wide = sw; dst_fmt = df; dst_wide = dw;
    e = model(d, sf, sw, df, dw, tag);
    sb.push_back(e);
    last_data = e.data; last_ovf = e.ovf; last_nz = e.nz;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard as results appear
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R3 unexpected out_valid", 18'd1, 18'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({out_negz, out_ovf, out_data} == {e.nz, e.ovf, e.data}, e.tag,
              {out_negz, out_ovf, out_data}, {e.nz, e.ovf, e.data});
      end
    end
  end

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lcg;
    repeat (3) @(negedge clk);
    // R3 reset state
    check({out_valid, out_ovf, out_negz, out_data} == '0, "R3 reset state",
          {out_ovf, out_negz, out_data}, 18'd0);
    rst_n = 1'b1;
    idle(1);
    // R4 directed
    send(16'h00BB, 2'b00, 0, 2'b10, 0, "R4 smag -59 to twos8");
    send(16'h0007, 2'b10, 0, 2'b01, 1, "R4 +7 to ones16");
    send(16'h00F9, 2'b10, 0, 2'b00, 1, "R4 twos8 -7 to smag16");
    send(16'hFF83, 2'b01, 1, 2'b10, 0, "R4 ones16 -124 to twos8");
    // R1 code 3 acts as twos
    send(16'h00F9, 2'b11, 0, 2'b00, 0, "R1 code3 source");
    send(16'h8000, 2'b00, 1, 2'b11, 1, "R1 code3 dest");
    // R2 upper bits ignored for narrow source
    send(16'hA57C, 2'b00, 0, 2'b10, 1, "R2 upper ignored");
    send(16'h5A7C, 2'b00, 0, 2'b10, 1, "R2 upper ignored alt");
    // R5 negative zeros
    send(16'h0080, 2'b00, 0, 2'b10, 1, "R5 smag8 -0");
    send(16'h8000, 2'b00, 1, 2'b01, 0, "R5 smag16 -0");
    send(16'h00FF, 2'b01, 0, 2'b00, 0, "R5 ones8 -0");
    send(16'hFFFF, 2'b01, 1, 2'b10, 1, "R5 ones16 -0");
    // R6 overflow narrowing
    send(16'h0102, 2'b10, 1, 2'b10, 0, "R6 +258 to 8");
    send(16'h9F48, 2'b10, 1, 2'b00, 0, "R6 -24760 to 8");
    send(16'hFF80, 2'b10, 1, 2'b00, 0, "R6 -128 to smag8");
    send(16'hFF80, 2'b10, 1, 2'b10, 0, "R6 -128 to twos8 fits");
    send(16'h007F, 2'b10, 1, 2'b01, 0, "R6 +127 fits");
    send(16'h0080, 2'b10, 1, 2'b01, 0, "R6 +128 overflows");
    // R7 most negative two's complement
    send(16'h0080, 2'b10, 0, 2'b00, 0, "R7 -128 to smag8");
    send(16'h0080, 2'b10, 0, 2'b01, 0, "R7 -128 to ones8");
    send(16'h8000, 2'b10, 1, 2'b01, 1, "R7 -32768 to ones16");
    send(16'h8000, 2'b10, 1, 2'b00, 1, "R7 -32768 to smag16");
    send(16'h0080, 2'b10, 0, 2'b01, 1, "R7 -128 widened");
    // R8 widening
    send(16'h00FF, 2'b00, 0, 2'b10, 1, "R8 smag -127 wide");
    send(16'h0081, 2'b01, 0, 2'b00, 1, "R8 ones -126 wide");
    idle(2);
    // R9 outputs hold while idle, upper-bit junk on inputs
    in_data = 16'h1234; src_fmt = 2'b01; dst_fmt = 2'b00; src_wide = 1; dst_wide = 0;
    idle(3);
    check({out_valid, out_negz, out_ovf, out_data} == {1'b0, last_nz, last_ovf, last_data},
          "R9 hold while idle", {out_negz, out_ovf, out_data}, {last_nz, last_ovf, last_data});
    // sweep: back-to-back requests over all codes and widths (R1 R4 R6)
    lcg = 32'h1234_5678;
    for (int i = 0; i < 400; i++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send(lcg[31:16], lcg[1:0], lcg[2], lcg[4:3], lcg[5], "R4 sweep");
      if (lcg[9:7] == 3'd0) idle(1);
    end
    idle(3);
    check(sb.size() == 0, "R3 scoreboard drained", 18'(sb.size()), 18'd0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule